// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is the controlling end of a four-wire synchronous serial link. One request moves a word of programmable length in both directions at once with one of several peripherals. Each peripheral has its own active-low select output. Per transfer, the caller picks the serial clock rate, the idle level and the sampling phase of the serial clock, the word length, which peripheral to address, and a wait between select assertion and the first clock edge. That wait covers peripherals that need settling or conversion time.

A transfer begins with a one-cycle `start` while the block is idle. The block lowers the chosen select line and waits the programmed time. It then toggles the serial clock, puts out the transmit word most significant bit first, and collects the incoming bits into the same shift register. At the end it presents the received word with a one-cycle `done`. While `stream` is high, select stays low after a word. A further `start` then reloads the shift register and sends the next word at once. Dropping `stream` ends the sequence. The select line then rises and stays high for a full serial clock period before the block accepts new work.

Top module: `spi_host_ctrl`

## Requirements
- R1: The data line is sampled on the rising serial clock edge for (cpol,cpha) = (0,0) and (1,1), and on the falling edge for (0,1) and (1,0). Outgoing data changes only on the opposite edge. With cpha=0 the first bit is on `mosi` before the first edge.
- R2: Outside a word, `sclk` rests at the latched `cfg_cpol` level, including when `done` is raised and while select is held between stream words.
- R3: Each half period of `sclk` lasts exactly `cfg_div` system cycles, and a `cfg_div` of 0 behaves as 1.
- R4: At most one `ss_n` bit is low at any time. During a transfer it is bit `cfg_sel` (index 0 is `ss_n[0]`).
- R5: The first `sclk` edge of a transfer comes exactly `cfg_wait + cfg_div + 1` system cycles after the select line falls.
- R6: Words of `cfg_len` bits (1 to MAX_W) leave on `mosi` most significant bit first. The bits received on `miso` form `rx_word`, right-aligned, with all bits above the word length zero.
- R7: `done` is high for exactly one cycle per word, in the cycle in which `rx_word` first holds that word.
- R8: When `stream` is high after a word, select stays low and `sclk` stays idle. A `start` then sends `tx_word` as the next word without the setup wait and without releasing select. When `stream` is low after a word, select is released.
- R9: Between separate transfers, every select line stays high for at least `2*cfg_div` system cycles.
- R10: `busy` is high from the accepted `start` until the release gap ends. A `start` while busy is ignored, except as the stream continuation of R8: it launches no word and changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse: begin a transfer, or send the next stream word |
| stream | input | 1 | Keep select low after the current word |
| cfg_div | input | DIV_W | Half period of `sclk` in system cycles |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_len | input | LEN_W | Word length in bits |
| cfg_sel | input | SEL_W | Index of the peripheral to select |
| cfg_wait | input | WAIT_W | Extra cycles between select assertion and the first clock edge |
| tx_word | input | MAX_W | Word to send, right-aligned |
| busy | output | 1 | Transfer or release gap in progress |
| done | output | 1 | One-cycle pulse: a word has finished |
| rx_word | output | MAX_W | Last received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| ss_n | output | NSEL | Active-low select, one bit per peripheral |

## Verification
The hardest situation to reach is the stream hand-over. `done` must be observed, then a new `start` must land while select is still held, and `stream` must be dropped only after the last word has been accepted. Otherwise the block either releases select early or never leaves the hold. The bench reaches this by reacting in the same half cycle in which it sees `done`. The peripheral model reloads its reply at each word boundary from a queue filled before the sequence starts, so the first bit of each following word is present before the first clock edge. With cpha=1, the last sampling edge and the select release must not coincide. This is exercised in every mode by a behavioural peripheral that reads `mosi` at its own sampling edges.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } host_state_e;

endpackage

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DIV_ONE = 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == half_div - DIV_ONE);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: a tick restarts the half period, so two ticks in a row need a half period of 1
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_div > DIV_ONE) |=> !tick);

endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
    parameter int NSEL  = 4,
    parameter int SEL_W = 2
) (
    input  logic             active,
    input  logic [SEL_W-1:0] idx,
    output logic [NSEL-1:0]  sel_n
);
    for (genvar g = 0; g < NSEL; g++) begin : g_line
        assign sel_n[g] = !(active && (idx == SEL_W'(g)));
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter  int NSEL   = 4,
    parameter  int MAX_W  = 16,
    parameter  int DIV_W  = 8,
    parameter  int WAIT_W = 8,
    localparam int SEL_W  = (NSEL > 1) ? $clog2(NSEL) : 1,
    localparam int LEN_W  = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stream,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [MAX_W-1:0]  tx_word,
    output logic              busy,
    output logic              done,
    output logic [MAX_W-1:0]  rx_word,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSEL-1:0]   ss_n
);
    localparam int EDGE_W = LEN_W + 1;
    localparam int CNT_W  = (WAIT_W > DIV_W + 1) ? WAIT_W : DIV_W + 1;
    localparam logic [CNT_W-1:0]  CNT_ONE  = 1;
    localparam logic [EDGE_W-1:0] EDGE_ONE = 1;
    localparam logic [DIV_W-1:0]  DIV_ONE  = 1;
    localparam logic [MAX_W-1:0]  W_ONE    = 1;
    localparam logic [LEN_W-1:0]  LEN_ONE  = 1;
    localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(MAX_W);

    typedef struct packed {
        host_state_e       state;
        logic              cpol;
        logic              cpha;
        logic [LEN_W-1:0]  len;
        logic [SEL_W-1:0]  sel;
        logic [DIV_W-1:0]  div;
        logic [WAIT_W-1:0] setup;
        logic [MAX_W-1:0]  sr;
        logic              smp;
        logic [EDGE_W-1:0] eidx;
        logic [CNT_W-1:0]  cnt;
        logic              sclk;
        logic [MAX_W-1:0]  rx;
        logic              done;
    } host_regs_t;

    host_regs_t r_d, r_q;

    logic              tick;
    logic              sel_on;
    logic              sample_edge;
    logic [LEN_W-1:0]  len_fix;
    logic [DIV_W-1:0]  div_fix;
    logic [EDGE_W-1:0] last_e;
    logic [CNT_W-1:0]  gap_last;
    logic [MAX_W-1:0]  len_mask;
    logic [MAX_W-1:0]  shifted;
    logic [MAX_W-1:0]  final_word;

    spi_edge_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.state == ST_SHIFT),
        .half_div (r_q.div),
        .tick     (tick)
    );

    spi_sel_decode #(.NSEL(NSEL), .SEL_W(SEL_W)) u_sel (
        .active (sel_on),
        .idx    (r_q.sel),
        .sel_n  (ss_n)
    );

    always_comb begin
        if (cfg_len == '0) begin
            len_fix = LEN_ONE;
        end else if (cfg_len > LEN_MAX) begin
            len_fix = LEN_MAX;
        end else begin
            len_fix = cfg_len;
        end
        div_fix     = (cfg_div == '0) ? DIV_ONE : cfg_div;
        last_e      = EDGE_W'({r_q.len, 1'b0}) - EDGE_ONE;
        gap_last    = CNT_W'({r_q.div, 1'b0}) - CNT_ONE;
        len_mask    = (W_ONE << r_q.len) - W_ONE;
        sample_edge = ~r_q.eidx[0] ^ r_q.cpha;
        shifted     = {r_q.sr[MAX_W-2:0], r_q.smp};
        final_word  = {r_q.sr[MAX_W-2:0], (r_q.cpha ? miso : r_q.smp)};
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                r_d.cpol = cfg_cpol;
                r_d.sclk = cfg_cpol;
                if (start) begin
                    r_d.cpha  = cfg_cpha;
                    r_d.len   = len_fix;
                    r_d.sel   = cfg_sel;
                    r_d.div   = div_fix;
                    r_d.setup = cfg_wait;
                    r_d.sr    = tx_word;
                    r_d.cnt   = '0;
                    r_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(r_q.setup)) begin
                    r_d.eidx  = '0;
                    r_d.state = ST_SHIFT;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_ONE;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    r_d.sclk = ~r_q.sclk;
                    r_d.eidx = r_q.eidx + EDGE_ONE;
                    if (r_q.eidx == last_e) begin
                        r_d.rx    = final_word & len_mask;
                        r_d.done  = 1'b1;
                        r_d.state = ST_HOLD;
                    end else if (sample_edge) begin
                        r_d.smp = miso;
                    end else if (!(r_q.cpha && r_q.eidx == '0)) begin
                        r_d.sr = shifted;
                    end
                end
            end
            ST_HOLD: begin
                if (stream && start) begin
                    r_d.sr    = tx_word;
                    r_d.eidx  = '0;
                    r_d.state = ST_SHIFT;
                end else if (!stream) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_GAP;
                end
            end
            ST_GAP: begin
                if (r_q.cnt == gap_last) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_ONE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_on  = (r_q.state == ST_SETUP) || (r_q.state == ST_SHIFT) || (r_q.state == ST_HOLD);
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign rx_word = r_q.rx;
    assign sclk    = r_q.sclk;
    assign mosi    = |(r_q.sr & (W_ONE << (r_q.len - LEN_ONE)));

    p_single_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ss_n) <= 1);

    p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETUP || r_q.state == ST_HOLD) |=> $stable(r_q.sclk));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD) |-> (ss_n != '1));

    p_gap_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GAP) |-> (ss_n == '1));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.state != ST_HOLD && start)
            |=> ($stable(r_q.sel) && $stable(r_q.len) && $stable(r_q.div)));

endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSEL = 4, MAX_W = 16, DIV_W = 8, WAIT_W = 8;
    localparam int SEL_W = 2, LEN_W = 5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stream = 1'b0;
    logic [DIV_W-1:0]  cfg_div  = 8'd2;
    logic              cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [LEN_W-1:0]  cfg_len  = 5'd8;
    logic [SEL_W-1:0]  cfg_sel  = '0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic [MAX_W-1:0]  tx_word  = '0;
    logic busy, done, sclk, mosi, miso;
    logic [MAX_W-1:0] rx_word;
    logic [NSEL-1:0]  ss_n;

    spi_host_ctrl #(.NSEL(NSEL), .MAX_W(MAX_W), .DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stream(stream), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len(cfg_len), .cfg_sel(cfg_sel),
        .cfg_wait(cfg_wait), .tx_word(tx_word), .busy(busy), .done(done), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0, n_done = 0, n_rise = 0;
    bit finished = 0;
    logic [15:0] exp_rx_q[$], exp_slv_q[$], resp_q[$];

    function automatic logic [15:0] msk(input logic [15:0] v, input int n);
        return (n >= 16) ? v : (v & ((16'd1 << n) - 16'd1));
    endfunction

    function automatic int eff_div();
        return (cfg_div == 0) ? 1 : int'(cfg_div);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral model: reacts to sclk edges seen at the falling system clock edge
    logic [15:0] s_out = '0, s_in = '0;
    int  s_ei = 0;
    bit  s_sel = 0;
    logic s_sclk = 1'b0;
    assign miso = s_out[int'(cfg_len) - 1];

    always @(negedge clk) begin
        bit lead, samp, now_sel;
        now_sel = (ss_n != '1);
        if (s_sel && sclk != s_sclk) begin
            lead = (s_ei % 2 == 0);
            samp = lead ^ cfg_cpha;
            if (samp) s_in = {s_in[14:0], mosi};
            else if (!(cfg_cpha && s_ei == 0)) s_out = s_out << 1;
            s_ei++;
            if (s_ei == 2 * int'(cfg_len)) begin
                s_ei = 0;
                if (exp_slv_q.size() == 0) chk(0, "R6", "peripheral got unexpected word", s_in, 0);
                else begin
                    logic [15:0] e;
                    e = exp_slv_q.pop_front();
                    // R1 R6: peripheral sampled the master's word MSB first
                    chk(msk(s_in, cfg_len) == e, "R1", "word seen by peripheral", msk(s_in, cfg_len), e);
                end
                if (resp_q.size() != 0) s_out = resp_q.pop_front();
            end
        end
        if (!s_sel && now_sel) begin
            s_ei = 0;
            if (resp_q.size() != 0) s_out = resp_q.pop_front();
        end
        s_sel  = now_sel;
        s_sclk = sclk;
    end

    // Monitor: timing, select and scoreboard of received words
    int  cyc = 0, gap_cnt = 0, gap_need = 0, phase = 0;
    bit  m_sel = 0, had_rise = 0, done_prev = 0;
    logic m_sclk = 1'b0;

    always @(negedge clk) begin
        bit now_sel;
        if (rst_n) begin
            now_sel = (ss_n != '1);
            cyc++;
            gap_cnt++;
            if (done_prev) chk(!done, "R7", "done longer than one cycle", done, 0);
            done_prev = done;
            if (m_sel && sclk != m_sclk) begin
                if (phase == 1) chk(cyc == int'(cfg_wait) + eff_div() + 1, "R5", "select to first edge", cyc, int'(cfg_wait) + eff_div() + 1);
                else if (phase == 0) chk(cyc == eff_div(), "R3", "half period", cyc, eff_div());
                phase = 0;
                cyc = 0;
            end
            if (now_sel && !m_sel) begin
                chk(ss_n == ~(4'b0001 << cfg_sel), "R4", "select lines", ss_n, ~(4'b0001 << cfg_sel));
                if (had_rise) chk(gap_cnt >= gap_need, "R9", "select high gap", gap_cnt, gap_need);
                cyc = 0;
                phase = 1;
            end
            if (!now_sel && m_sel) begin
                n_rise++;
                had_rise = 1;
                gap_cnt = 0;
                gap_need = 2 * eff_div();
                chk(sclk == cfg_cpol, "R2", "sclk level at release", sclk, cfg_cpol);
            end
            if (done) begin
                n_done++;
                phase = 2;
                chk(sclk == cfg_cpol, "R2", "sclk idle at done", sclk, cfg_cpol);
                if (exp_rx_q.size() == 0) chk(0, "R10", "unexpected done", rx_word, 0);
                else begin
                    logic [15:0] e;
                    e = exp_rx_q.pop_front();
                    chk(rx_word == e, "R6", "received word", rx_word, e);
                end
            end
            m_sel  = now_sel;
            m_sclk = sclk;
        end
    end

    task automatic setup_cfg(input int sel, input int len, input bit cpol, input bit cpha, input int div, input int wt);
        while (busy) @(negedge clk);
        cfg_sel = SEL_W'(sel); cfg_len = LEN_W'(len); cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_div = DIV_W'(div); cfg_wait = WAIT_W'(wt);
    endtask

    task automatic push_word(input logic [15:0] tx, input logic [15:0] resp);
        exp_rx_q.push_back(msk(resp, cfg_len));
        exp_slv_q.push_back(msk(tx, cfg_len));
        resp_q.push_back(resp);
    endtask

    task automatic pulse_start(input logic [15:0] tx);
        tx_word = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input int sel, input int len, input bit cpol, input bit cpha, input int div, input int wt,
                        input logic [15:0] tx, input logic [15:0] resp);
        setup_cfg(sel, len, cpol, cpha, div, wt);
        push_word(tx, resp);
        pulse_start(tx);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        int rises_before, done_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == '1, "R4", "reset select", ss_n, 4'hF);
        chk(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
        chk(sclk == 1'b0, "R2", "reset sclk", sclk, 0);

        // R1: all four clock modes
        send(0, 8, 0, 0, 2, 3, 16'h00A5, 16'h003C);
        send(1, 8, 0, 1, 2, 0, 16'h0081, 16'h00E7);
        send(2, 8, 1, 0, 3, 1, 16'h005A, 16'h00C3);
        send(3, 8, 1, 1, 1, 2, 16'h00F0, 16'h000F);
        // R3 divider 0 behaves as 1; R6 odd, full and single-bit lengths
        send(0, 5, 0, 0, 0, 0, 16'hFFF6, 16'hFFED);
        send(1, 16, 1, 1, 2, 4, 16'hB00C, 16'h4DE1);
        send(2, 1, 0, 1, 1, 0, 16'h0001, 16'h0001);
        send(3, 1, 1, 0, 1, 0, 16'h0000, 16'h0001);

        // R8: three-word stream with cpha=1
        setup_cfg(1, 12, 0, 1, 2, 5);
        rises_before = n_rise;
        push_word(16'h0ABC, 16'h0123); push_word(16'h0F0F, 16'h0E1D); push_word(16'h0777, 16'h0888);
        stream = 1'b1;
        pulse_start(16'h0ABC);
        wait_done();
        start = 1'b1; tx_word = 16'h0F0F; @(negedge clk); start = 1'b0;
        wait_done();
        start = 1'b1; tx_word = 16'h0777; @(negedge clk); start = 1'b0; stream = 1'b0;
        wait_done();
        while (busy) @(negedge clk);
        chk(n_rise - rises_before == 1, "R8", "select releases in stream", n_rise - rises_before, 1);

        // R8: two-word stream with cpha=0
        setup_cfg(3, 9, 1, 0, 3, 2);
        rises_before = n_rise;
        push_word(16'h01A3, 16'h0155); push_word(16'h00C6, 16'h01FE);
        stream = 1'b1;
        pulse_start(16'h01A3);
        wait_done();
        start = 1'b1; tx_word = 16'h00C6; @(negedge clk); start = 1'b0; stream = 1'b0;
        wait_done();
        while (busy) @(negedge clk);
        chk(n_rise - rises_before == 1, "R8", "select releases in stream", n_rise - rises_before, 1);

        // R10: starts while shifting and during the release gap are ignored
        done_before = n_done;
        send(2, 8, 0, 0, 4, 2, 16'h00A5, 16'h005A);
        repeat (12) @(negedge clk);
        pulse_start(16'h003C);
        wait_done();
        @(negedge clk);
        chk(busy, "R10", "busy during gap", busy, 1);
        pulse_start(16'h00FF);
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(n_done - done_before == 1, "R10", "words launched", n_done - done_before, 1);
        chk(ss_n == '1, "R10", "select after ignored start", ss_n, 4'hF);

        // R9: back-to-back transfers with a wide divider
        send(0, 4, 1, 1, 5, 0, 16'h0009, 16'h0006);
        send(1, 4, 1, 1, 5, 0, 16'h0003, 16'h000C);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);

        chk(exp_rx_q.size() == 0, "R7", "words outstanding", exp_rx_q.size(), 0);
        chk(exp_slv_q.size() == 0, "R6", "peripheral words outstanding", exp_slv_q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule